// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses where a microprogrammed controller fetches its next microinstruction. On every clock it reads a 2-bit next-address mode from the microinstruction being executed. It also takes a jump target from that microinstruction, the 16-bit opcode of the machine instruction and a flag that is high when the accumulator holds zero. From these it forms the next microaddress, registers it, and drives the same value combinationally onto a read-address output so that a synchronous control store can be read one cycle ahead.

There are four transitions, and the mode encoding picks one:

- **STEP** advances by one.
- **DISPATCH** enters the routine that belongs to the opcode.
- **JUMP** loads the target carried in the microinstruction.
- **SKIP** advances by two when the accumulator is zero and by one otherwise.

Conditional branching is built from SKIP alone. A SKIP at the start of the routine either falls onto a JUMP that leads to the not-taken path, or jumps over it into the taken path.

An opcode outside the defined set is not dispatched. The microaddress stays where it was, and a one-cycle illegal-opcode flag is raised.

Top module: `microseq_next`

## Requirements
- R1: While reset (active low) is held and on the first cycle after release, the microaddress is 0 (the fetch entry) and the illegal flag is 0.
- R2: Mode 2'b00 (STEP) makes the microaddress equal to its previous value plus one, modulo 128.
- R3: Mode 2'b10 (JUMP) loads the 7-bit jump target from the microinstruction into the microaddress.
- R4: Mode 2'b01 (DISPATCH) with an opcode of exactly 10, 20, 30, 40, 50, 60 or 70 (decimal, all 16 bits compared) loads the microaddress with that same value, and the illegal flag is 0 on the following cycle.
- R5: Mode 2'b01 with any other opcode, including values whose low 7 bits match a legal entry, leaves the microaddress unchanged and sets the illegal flag for exactly the following cycle. The flag is never set after any other mode.
- R6: Mode 2'b11 (SKIP) adds 2 to the microaddress when the accumulator-zero input is 1 and adds 1 when it is 0, modulo 128.
- R7: STEP from 127 gives 0. SKIP from 126 with a zero accumulator gives 0, and SKIP from 127 gives 1 or 0 by the same rule.
- R8: The read-address output always equals the value the microaddress takes at the next clock edge.
- R9: The conditional-branch routine (60: SKIP, 61: JUMP 64, 62: STEP, 63: JUMP 0, 64 to 67: STEP, 68: JUMP 0), dispatched from 0 with opcode 60, visits 60, 62, 63, 0 when the accumulator is zero. Otherwise it visits 60, 61, 64, 65, 66, 67, 68, 0, with no address repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| nxt_mode_i | input | 2 | Next-address mode: 00 STEP, 01 DISPATCH, 10 JUMP, 11 SKIP |
| jump_addr_i | input | 7 | Jump target from the microinstruction |
| opcode_i | input | 16 | Machine instruction opcode to dispatch |
| acc_zero_i | input | 1 | High when the accumulator is zero |
| uaddr_o | output | 7 | Registered microaddress |
| rom_addr_o | output | 7 | Next microaddress, for a synchronous control-store read |
| bad_op_o | output | 1 | Illegal-opcode flag, one cycle after a failed dispatch |

## Verification
The assertions assume the following about the inputs:

- The mode, jump target, opcode and accumulator-zero inputs carry known values whenever reset is released.
- These inputs are stable around each rising edge.
- The opcode and zero flag only matter in the modes that read them.

The bench drives every input at the falling edge from a single task and never leaves a mode undriven. It sweeps all jump targets and both zero-flag values over every start address, and passes opcodes 0 to 299 plus high-bit aliases through DISPATCH. This keeps the stimulus inside those assumptions while still covering every branch of the mode decode.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W     = 7;
    localparam int OP_W     = 16;
    localparam int ROUTINES = 7;
    localparam int STRIDE   = 10;

    typedef enum logic [1:0] {
        NX_STEP     = 2'b00,
        NX_DISPATCH = 2'b01,
        NX_JUMP     = 2'b10,
        NX_SKIP     = 2'b11
    } nx_mode_e;

endpackage

// File: rtl/useq_opmap.sv
module useq_opmap
    import useq_pkg::*;
#(
    parameter int OPW  = OP_W,
    parameter int AW   = UA_W,
    parameter int NRT  = ROUTINES,
    parameter int STEP = STRIDE
) (
    input  logic [OPW-1:0] opcode_i,
    output logic [AW-1:0]  entry_o,
    output logic           legal_o
);

    localparam int TOP_CODE = NRT * STEP;

    logic [NRT-1:0] hit;

    // one comparator per defined routine
    generate
        for (genvar i = 0; i < NRT; i++) begin : g_code
            localparam logic [OPW-1:0] CODE = OPW'((i + 1) * STEP);
            assign hit[i] = (opcode_i == CODE);
        end
    endgenerate

    always_comb begin
        entry_o = '0;
        for (int i = 0; i < NRT; i++) begin
            if (hit[i]) begin
                entry_o = AW'((i + 1) * STEP);
            end
        end
    end

    assign legal_o = |hit;

    initial begin
        if (TOP_CODE >= (1 << AW)) begin
            $display("useq_opmap: routine entries exceed address space");
        end
    end

endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
    import useq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  nx_mode_e       mode_i,
    input  logic [AW-1:0]  cur_i,
    input  logic [AW-1:0]  jump_i,
    input  logic [AW-1:0]  entry_i,
    input  logic           entry_ok_i,
    input  logic           acc_zero_i,
    output logic [AW-1:0]  nxt_o,
    output logic           bad_o
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    always_comb begin
        nxt_o = cur_i;
        bad_o = 1'b0;
        unique case (mode_i)
            NX_STEP: begin
                nxt_o = cur_i + ONE;
            end
            NX_DISPATCH: begin
                if (entry_ok_i) begin
                    nxt_o = entry_i;
                end else begin
                    nxt_o = cur_i;
                    bad_o = 1'b1;
                end
            end
            NX_JUMP: begin
                nxt_o = jump_i;
            end
            NX_SKIP: begin
                nxt_o = cur_i + (acc_zero_i ? TWO : ONE);
            end
            default: begin
                nxt_o = cur_i;
            end
        endcase
    end

endmodule

// File: rtl/microseq_next.sv
module microseq_next
    import useq_pkg::*;
#(
    parameter int AW  = UA_W,
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     nxt_mode_i,
    input  logic [AW-1:0]  jump_addr_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic           acc_zero_i,
    output logic [AW-1:0]  uaddr_o,
    output logic [AW-1:0]  rom_addr_o,
    output logic           bad_op_o
);

    localparam logic [AW-1:0] FETCH_ENTRY = '0;

    nx_mode_e      mode;
    logic [AW-1:0] ua_q;
    logic          bad_q;
    logic [AW-1:0] entry;
    logic          entry_ok;
    logic [AW-1:0] ua_nxt;
    logic          bad_nxt;

    assign mode = nx_mode_e'(nxt_mode_i);

    useq_opmap #(
        .OPW (OPW),
        .AW  (AW)
    ) u_opmap (
        .opcode_i (opcode_i),
        .entry_o  (entry),
        .legal_o  (entry_ok)
    );

    useq_nextsel #(
        .AW (AW)
    ) u_nextsel (
        .mode_i     (mode),
        .cur_i      (ua_q),
        .jump_i     (jump_addr_i),
        .entry_i    (entry),
        .entry_ok_i (entry_ok),
        .acc_zero_i (acc_zero_i),
        .nxt_o      (ua_nxt),
        .bad_o      (bad_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ua_q  <= FETCH_ENTRY;
            bad_q <= 1'b0;
        end else begin
            ua_q  <= ua_nxt;
            bad_q <= bad_nxt;
        end
    end

    // outputs
    always_comb begin
        uaddr_o    = ua_q;
        bad_op_o   = bad_q;
        rom_addr_o = rst_n ? ua_nxt : FETCH_ENTRY;
    end

endmodule

// File: rtl/microseq_next_chk.sv
module microseq_next_chk #(
    parameter int AW  = 7,
    parameter int OPW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     nxt_mode_i,
    input logic [AW-1:0]  jump_addr_i,
    input logic [OPW-1:0] opcode_i,
    input logic           acc_zero_i,
    input logic [AW-1:0]  uaddr_o,
    input logic [AW-1:0]  rom_addr_o,
    input logic           bad_op_o
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i == 2'b00 |=> uaddr_o == AW'($past(uaddr_o) + ONE)); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i == 2'b10 |=> uaddr_o == $past(jump_addr_i)); // R3

    AST_DISPATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i == 2'b01 |=> (bad_op_o || uaddr_o == $past(opcode_i[AW-1:0]))); // R4

    AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i == 2'b01 ##1 bad_op_o |-> $stable(uaddr_o)); // R5

    AST_BAD_ONLY_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i != 2'b01 |=> !bad_op_o); // R5

    AST_SKIP_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_mode_i == 2'b11 |=>
            uaddr_o == AW'($past(uaddr_o) + ($past(acc_zero_i) ? TWO : ONE))); // R6

    AST_ROM_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> uaddr_o == $past(rom_addr_o)); // R8

endmodule

bind microseq_next microseq_next_chk #(
    .AW  (AW),
    .OPW (OPW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_mode_i  (nxt_mode_i),
    .jump_addr_i (jump_addr_i),
    .opcode_i    (opcode_i),
    .acc_zero_i  (acc_zero_i),
    .uaddr_o     (uaddr_o),
    .rom_addr_o  (rom_addr_o),
    .bad_op_o    (bad_op_o)
);

// File: tb/test_microseq_next.sv
`timescale 1ns/1ps
module test_microseq_next;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [6:0]  jaddr = '0;
    logic [15:0] opc = '0;
    logic        zflag = 1'b0;
    logic [6:0]  uaddr;
    logic [6:0]  rom_addr;
    logic        bad;

    int checks = 0;
    int errors = 0;
    int exp_ua = 0;

    always #10 clk = ~clk;

    microseq_next i_microseq_next (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_mode_i  (mode),
        .jump_addr_i (jaddr),
        .opcode_i    (opc),
        .acc_zero_i  (zflag),
        .uaddr_o     (uaddr),
        .rom_addr_o  (rom_addr),
        .bad_op_o    (bad)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit op_legal(input int op);
        return (op >= 10) && (op <= 70) && (op % 10 == 0);
    endfunction

    // one microcycle: drive at falling edge, check ahead address, check result after edge
    task automatic step(input logic [1:0] m, input int ja, input int op, input bit z,
                        input string req);
        int nxt;
        int bad_exp;
        @(negedge clk);
        mode = m; jaddr = 7'(ja); opc = 16'(op); zflag = z;
        bad_exp = 0;
        case (m)
            2'b00: nxt = (exp_ua + 1) % 128;
            2'b10: nxt = ja % 128;
            2'b11: nxt = (exp_ua + (z ? 2 : 1)) % 128;
            default: begin
                if (op_legal(op)) nxt = op;
                else begin nxt = exp_ua; bad_exp = 1; end
            end
        endcase
        #2;
        chk("R8", "read address", int'(rom_addr), nxt);
        @(posedge clk);
        #2;
        exp_ua = nxt;
        chk(req, "microaddress", int'(uaddr), nxt);
        chk(req, "illegal flag", int'(bad), bad_exp);
    endtask

    // routine table used for the conditional branch sequence
    task automatic table_entry(input int a, output logic [1:0] m, output int ja);
        m = 2'b00; ja = 0;
        if (a == 60) m = 2'b11;
        else if (a == 61) begin m = 2'b10; ja = 64; end
        else if (a == 63 || a == 68) begin m = 2'b10; ja = 0; end
    endtask

    task automatic run_cbr(input bit z);
        int path[8];
        int n;
        logic [1:0] m;
        int ja;
        step(2'b10, 0, 0, z, "R9");
        step(2'b01, 0, 60, z, "R9");
        n = 0;
        path[n++] = int'(uaddr);
        while (int'(uaddr) != 0 && n < 8) begin
            table_entry(int'(uaddr), m, ja);
            step(m, ja, 0, z, "R9");
            path[n++] = int'(uaddr);
        end
        if (z) begin
            chk("R9", "taken length", n, 4);
            chk("R9", "taken[1]", path[1], 62);
            chk("R9", "taken[2]", path[2], 63);
            chk("R9", "taken[3]", path[3], 0);
        end else begin
            chk("R9", "not-taken length", n, 8);
            for (int k = 0; k < 8; k++) begin
                int e;
                e = (k == 0) ? 60 : (k == 1) ? 61 : (k == 7) ? 0 : 62 + k;
                chk("R9", "not-taken path", path[k], e);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds fetch entry even with active inputs
        mode = 2'b10; jaddr = 7'd99;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "in reset addr", int'(uaddr), 0);
        chk("R1", "in reset flag", int'(bad), 0);
        @(negedge clk);
        mode = 2'b00;
        rst_n = 1'b1;
        #2;
        chk("R1", "after release addr", int'(uaddr), 0);
        chk("R1", "after release flag", int'(bad), 0);
        exp_ua = 0;

        // R3 every jump target, R2 step from every address
        for (int a = 0; a < 128; a++) begin
            step(2'b10, a, 0, 0, "R3");
            step(2'b00, 0, 0, 0, (a == 127) ? "R7" : "R2");
        end
        // R6 skip from every address, both flag values
        for (int a = 0; a < 128; a++) begin
            for (int z = 0; z < 2; z++) begin
                step(2'b10, a, 0, 0, "R3");
                step(2'b11, 0, 0, z[0], (a >= 126) ? "R7" : "R6");
            end
        end
        // R4 / R5 dispatch sweep
        for (int op = 0; op < 300; op++) begin
            step(2'b10, 5, 0, 0, "R3");
            step(2'b01, 0, op, 0, op_legal(op) ? "R4" : "R5");
        end
        step(2'b10, 33, 0, 0, "R3");
        step(2'b01, 0, 16'h800A, 0, "R5");
        step(2'b01, 0, 16'hFFFF, 0, "R5");
        step(2'b00, 0, 0, 0, "R5");
        step(2'b01, 0, 16'h0046, 0, "R4");

        // R9 conditional branch routine both ways
        run_cbr(1'b1);
        run_cbr(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule